// File: doc/BRIEF.md
# Chip-Select Serial Frame Interface

This block is the host-facing serial front end of a display controller. A host microcontroller selects the block with a chip-select line and clocks in 64-bit frames on a serial data line. A 4-bit mode code at the tail of each frame selects the action. The frame can load the segment pattern for one of two display grids or an 11-bit dimming word. It can also stop key scanning, or ask for the scanned key state. While chip-select is low, the clock and data lines are ignored, so other peripherals can share them.

Every bit the block accepts also appears on a cascade output 64 shift edges later, so a second device can be chained behind this one. After a key-read command, the next chip-select window turns the shared data line around. The block then drives the 30 captured key bits back to the host, most significant bit first. All pad inputs are resynchronised to the block clock. Serial edges are detected in that clock domain.

Top module: `ser_frame_if`

## Requirements
- R1: While `rst_n` is low at a clock edge, all latched outputs, strobes, `ks_read_o`, `sdio_oe_o`, `sdio_out_o` and `cascade_o` go to 0.
- R2: While `cs_i` is low, `sclk_i` and `sdio_in_i` change nothing: no bit enters the frame register and `cascade_o` holds.
- R3: A frame is the data sampled on `sclk_i` rising edges while `cs_i` is high. On the falling edge of `cs_i` a command takes effect only if exactly 64 rising edges were seen. The frame is 30 filler bits, then a 30-bit payload sent MSB first, then the 4-bit mode sent MSB first (M3 first, M0 last).
- R4: Mode 0x1 copies the payload into `seg_g1_o` and pulses `ld_g1_o`. `seg_g1_o` changes at no other time.
- R5: Mode 0x2 copies the payload into `seg_g2_o` and pulses `ld_g2_o`. `seg_g2_o` changes at no other time.
- R6: Mode 0x3 copies the low 11 payload bits (the 11 bits sent just before the mode) into `dim_word_o` and pulses `ld_dim_o`. `dim_word_o` changes at no other time.
- R7: Mode 0x5 pulses `ks_stop_o` once.
- R8: Mode codes 0x0 and 0x6 to 0xF have no effect on any output.
- R9: `cascade_o` presents the bit accepted 64 accepted shift edges earlier and updates on each accepted rising edge.
- R10: Mode 0x4 captures `key_data_i` and raises `ks_read_o`. In the next chip-select-high window the block drives `sdio_oe_o` high and presents the captured bits on `sdio_out_o`, MSB first. Bit 29 is valid before the first rising edge, and each later bit follows a rising edge. Input data in that window is ignored. `ks_read_o` clears when the window ends.
- R11: `sdio_oe_o` is low whenever chip-select is low, including while a key read is pending.
- R12: Each strobe (`ld_g1_o`, `ld_g2_o`, `ld_dim_o`, `ks_stop_o`) lasts one clock cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select from host, high selects |
| sclk_i | input | 1 | Serial clock from host |
| sdio_in_i | input | 1 | Data line as seen at the pad input |
| sdio_out_o | output | 1 | Data driven onto the line during a key read |
| sdio_oe_o | output | 1 | Output enable for the data line pad |
| cascade_o | output | 1 | Input stream delayed by 64 shift edges |
| key_data_i | input | 30 | Key state from the key scanner |
| seg_g1_o | output | 30 | Latched segment pattern for grid 1 |
| seg_g2_o | output | 30 | Latched segment pattern for grid 2 |
| dim_word_o | output | 11 | Latched digital dimming word |
| ld_g1_o | output | 1 | One-cycle strobe, grid 1 pattern loaded |
| ld_g2_o | output | 1 | One-cycle strobe, grid 2 pattern loaded |
| ld_dim_o | output | 1 | One-cycle strobe, dimming word loaded |
| ks_stop_o | output | 1 | One-cycle strobe, stop key scanning |
| ks_read_o | output | 1 | Key read pending or in progress |

## Verification
Command frames are sent with payloads of all ones, all zeros, alternating bits and mixed values, under both valid and invalid mode codes. This shows whether the payload lands in the right register and whether unused codes truly leave everything alone. Frames of 63 and 65 edges separate the exact-count rule from plain decoding. Serial clock toggles with chip-select low show whether the select gate works. A key read is driven while the host sends a valid load frame on the input pin. This shows that the turnaround window both serialises the captured bits and blocks the input. The cascade tap is compared edge by edge against the accepted bit stream, so the exact 64-edge depth and the freeze during the read window are both observed.

// File: rtl/ser_frame_pkg.sv
// Shared constants and mode codes for the serial frame interface.
package ser_frame_pkg;
    localparam int FRAME_BITS = 64;
    localparam int MODE_W     = 4;
    localparam int SEG_W      = 30;
    localparam int DIM_W      = 11;
    localparam int KEY_W      = 30;

    typedef enum logic [MODE_W-1:0] {
        MODE_GRID1 = 4'h1,
        MODE_GRID2 = 4'h2,
        MODE_DIM   = 4'h3,
        MODE_KREAD = 4'h4,
        MODE_KSTOP = 4'h5
    } frame_mode_e;
endpackage

// File: rtl/ser_frame_sync.sv
// Two-stage resynchroniser for W asynchronous pad inputs.
// Assumes each input is stable for several clk cycles between changes.
module ser_frame_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two flops per bit; reset to 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                q_o[i]    <= 1'b0;
            end else begin
                stage1[i] <= d_i[i];
                q_o[i]    <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/ser_frame_shift.sv
// Frame shift register with edge detection, edge counter and cascade tap.
// Shifts on synchronised serial-clock rising edges while chip select is
// high and hold_i is low. Outputs only the low FIELD_W bits for decode.
module ser_frame_shift #(
    parameter int FRAME_BITS = 64,
    parameter int FIELD_W    = 34
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_s,
    input  logic               sclk_s,
    input  logic               din_s,
    input  logic               hold_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               cascade_o,
    output logic               shift_o,
    output logic               frame_end_o,
    output logic               frame_ok_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic                  sclk_q, cs_q;
    logic [CNT_W-1:0]      edge_cnt;
    logic [FRAME_BITS-1:0] sr;

    assign shift_o     = cs_s & sclk_s & ~sclk_q;
    assign frame_end_o = cs_q & ~cs_s;
    assign frame_ok_o  = frame_end_o & (edge_cnt == CNT_FULL) & ~hold_i;
    assign field_o     = sr[FIELD_W-1:0];

    // Previous values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
        end
    end

    // Count rising edges in the current select window, saturating past full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (cs_s & ~cs_q) begin
            edge_cnt <= '0;
        end else if (shift_o && edge_cnt != CNT_SAT) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // Shift accepted bits in at the bottom; the bit leaving the top feeds the tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr        <= '0;
            cascade_o <= 1'b0;
        end else if (shift_o && !hold_i) begin
            sr        <= {sr[FRAME_BITS-2:0], din_s};
            cascade_o <= sr[FRAME_BITS-1];
        end
    end
endmodule

// File: rtl/ser_frame_decode.sv
// Mode decoder and output latches. Acts on a complete frame (frame_ok_i)
// and tracks the key-read state, which ends with the following window.
module ser_frame_decode
    import ser_frame_pkg::*;
#(
    parameter int FIELD_W = MODE_W + SEG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_ok_i,
    input  logic               frame_end_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [SEG_W-1:0]   seg_g1_o,
    output logic [SEG_W-1:0]   seg_g2_o,
    output logic [DIM_W-1:0]   dim_word_o,
    output logic               ld_g1_o,
    output logic               ld_g2_o,
    output logic               ld_dim_o,
    output logic               ks_stop_o,
    output logic               key_load_o,
    output logic               read_active_o
);
    logic [MODE_W-1:0] mode;
    logic [SEG_W-1:0]  payload;

    assign mode    = field_i[MODE_W-1:0];
    assign payload = field_i[MODE_W+SEG_W-1:MODE_W];

    // Latch payloads and raise one-cycle strobes per mode code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_g1_o   <= '0;
            seg_g2_o   <= '0;
            dim_word_o <= '0;
            ld_g1_o    <= 1'b0;
            ld_g2_o    <= 1'b0;
            ld_dim_o   <= 1'b0;
            ks_stop_o  <= 1'b0;
            key_load_o <= 1'b0;
        end else begin
            ld_g1_o    <= 1'b0;
            ld_g2_o    <= 1'b0;
            ld_dim_o   <= 1'b0;
            ks_stop_o  <= 1'b0;
            key_load_o <= 1'b0;
            if (frame_ok_i) begin
                case (mode)
                    MODE_GRID1: begin
                        seg_g1_o <= payload;
                        ld_g1_o  <= 1'b1;
                    end
                    MODE_GRID2: begin
                        seg_g2_o <= payload;
                        ld_g2_o  <= 1'b1;
                    end
                    MODE_DIM: begin
                        dim_word_o <= payload[DIM_W-1:0];
                        ld_dim_o   <= 1'b1;
                    end
                    MODE_KREAD: key_load_o <= 1'b1;
                    MODE_KSTOP: ks_stop_o  <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Key-read state: set by a read command, cleared when the next window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_active_o <= 1'b0;
        end else if (frame_ok_i && mode == MODE_KREAD) begin
            read_active_o <= 1'b1;
        end else if (frame_end_i) begin
            read_active_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ser_frame_keyout.sv
// Key readout serialiser: captures key bits on key_load_i and presents
// them MSB first, advancing one bit after each accepted rising edge.
module ser_frame_keyout #(
    parameter int KEY_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_load_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             shift_i,
    input  logic             read_active_i,
    input  logic             cs_s,
    output logic             sdo_o,
    output logic             oe_o
);
    logic [KEY_W-1:0] kr;

    assign oe_o  = read_active_i & cs_s;
    assign sdo_o = oe_o & kr[KEY_W-1];

    // Capture on command, then shift left once per edge of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kr <= '0;
        end else if (key_load_i) begin
            kr <= key_i;
        end else if (shift_i && read_active_i) begin
            kr <= {kr[KEY_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ser_frame_if.sv
// Top of the chip-select serial frame interface: resynchronises the pads,
// shifts frames, decodes the mode field and serves key reads. Assumes the
// serial clock phases last at least four clk cycles each.
module ser_frame_if
    import ser_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_i,
    input  logic             sclk_i,
    input  logic             sdio_in_i,
    output logic             sdio_out_o,
    output logic             sdio_oe_o,
    output logic             cascade_o,
    input  logic [KEY_W-1:0] key_data_i,
    output logic [SEG_W-1:0] seg_g1_o,
    output logic [SEG_W-1:0] seg_g2_o,
    output logic [DIM_W-1:0] dim_word_o,
    output logic             ld_g1_o,
    output logic             ld_g2_o,
    output logic             ld_dim_o,
    output logic             ks_stop_o,
    output logic             ks_read_o
);
    localparam int FIELD_W = MODE_W + SEG_W;

    logic [2:0]         pads_s;
    logic               cs_s, sclk_s, din_s;
    logic [FIELD_W-1:0] field;
    logic               shift, frame_end, frame_ok, key_load, read_active;

    assign cs_s      = pads_s[2];
    assign sclk_s    = pads_s[1];
    assign din_s     = pads_s[0];
    assign ks_read_o = read_active;

    ser_frame_sync #(.W(3)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sclk_i, sdio_in_i}),
        .q_o   (pads_s)
    );

    ser_frame_shift #(.FRAME_BITS(FRAME_BITS), .FIELD_W(FIELD_W)) shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (cs_s),
        .sclk_s      (sclk_s),
        .din_s       (din_s),
        .hold_i      (read_active),
        .field_o     (field),
        .cascade_o   (cascade_o),
        .shift_o     (shift),
        .frame_end_o (frame_end),
        .frame_ok_o  (frame_ok)
    );

    ser_frame_decode #(.FIELD_W(FIELD_W)) decode_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_ok_i    (frame_ok),
        .frame_end_i   (frame_end),
        .field_i       (field),
        .seg_g1_o      (seg_g1_o),
        .seg_g2_o      (seg_g2_o),
        .dim_word_o    (dim_word_o),
        .ld_g1_o       (ld_g1_o),
        .ld_g2_o       (ld_g2_o),
        .ld_dim_o      (ld_dim_o),
        .ks_stop_o     (ks_stop_o),
        .key_load_o    (key_load),
        .read_active_o (read_active)
    );

    ser_frame_keyout #(.KEY_W(KEY_W)) keyout_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .key_load_i    (key_load),
        .key_i         (key_data_i),
        .shift_i       (shift),
        .read_active_i (read_active),
        .cs_s          (cs_s),
        .sdo_o         (sdio_out_o),
        .oe_o          (sdio_oe_o)
    );
endmodule

// File: rtl/ser_frame_if_chk.sv
// Property checker for ser_frame_if, attached by bind below.
module ser_frame_if_chk
    import ser_frame_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             sdio_oe_o,
    input logic             cascade_o,
    input logic [SEG_W-1:0] seg_g1_o,
    input logic [SEG_W-1:0] seg_g2_o,
    input logic [DIM_W-1:0] dim_word_o,
    input logic             ld_g1_o,
    input logic             ld_g2_o,
    input logic             ld_dim_o,
    input logic             ks_stop_o,
    input logic             ks_read_o
);
    // R4
    g1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seg_g1_o) |-> ld_g1_o);
    // R5
    g2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seg_g2_o) |-> ld_g2_o);
    // R6
    dim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dim_word_o) |-> ld_dim_o);
    // R2
    cascade_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cascade_o) |-> $past(cs_s));
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_g1_o, ld_g2_o, ld_dim_o, ks_stop_o}));
    // R12
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_g1_o | ld_g2_o | ld_dim_o | ks_stop_o) |=>
        !(ld_g1_o | ld_g2_o | ld_dim_o | ks_stop_o));
    // R10
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe_o |-> ks_read_o);
    // R10
    oe_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe_o |-> !(ld_g1_o | ld_g2_o | ld_dim_o | ks_stop_o));
endmodule

bind ser_frame_if ser_frame_if_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .sdio_oe_o  (sdio_oe_o),
    .cascade_o  (cascade_o),
    .seg_g1_o   (seg_g1_o),
    .seg_g2_o   (seg_g2_o),
    .dim_word_o (dim_word_o),
    .ld_g1_o    (ld_g1_o),
    .ld_g2_o    (ld_g2_o),
    .ld_dim_o   (ld_dim_o),
    .ks_stop_o  (ks_stop_o),
    .ks_read_o  (ks_read_o)
);

// File: tb/ser_frame_if_tb_top.sv
// Self-checking bench for ser_frame_if: vector table, then directed tests.
module ser_frame_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_i = 1'b0, sclk_i = 1'b0, sdio_in_i = 1'b0;
    logic        sdio_out_o, sdio_oe_o, cascade_o;
    logic [29:0] key_data_i = '0;
    logic [29:0] seg_g1_o, seg_g2_o;
    logic [10:0] dim_word_o;
    logic        ld_g1_o, ld_g2_o, ld_dim_o, ks_stop_o, ks_read_o;

    int n_tests = 0, n_fail = 0;
    int n_g1 = 0, n_g2 = 0, n_dim = 0, n_stop = 0;
    int casc_err = 0;
    logic [63:0] hist = '0;
    logic [29:0] exp_g1 = '0, exp_g2 = '0;
    logic [10:0] exp_dim = '0;

    always #10ns clk = ~clk;

    ser_frame_if dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i),
        .sdio_in_i(sdio_in_i), .sdio_out_o(sdio_out_o), .sdio_oe_o(sdio_oe_o),
        .cascade_o(cascade_o), .key_data_i(key_data_i),
        .seg_g1_o(seg_g1_o), .seg_g2_o(seg_g2_o), .dim_word_o(dim_word_o),
        .ld_g1_o(ld_g1_o), .ld_g2_o(ld_g2_o), .ld_dim_o(ld_dim_o),
        .ks_stop_o(ks_stop_o), .ks_read_o(ks_read_o)
    );

    // Strobe counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_g1   += int'(ld_g1_o);
            n_g2   += int'(ld_g2_o);
            n_dim  += int'(ld_dim_o);
            n_stop += int'(ks_stop_o);
        end
    end

    // {mode, payload}
    localparam logic [33:0] VEC [10] = '{
        {4'h1, 30'h12345678}, {4'h2, 30'h3FFF0001}, {4'h3, 30'h000005A5},
        {4'h0, 30'h3FFFFFFF}, {4'h5, 30'h00000000}, {4'hF, 30'h15555555},
        {4'h1, 30'h3FFFFFFF}, {4'h2, 30'h00000000}, {4'h6, 30'h2AAAAAAA},
        {4'h3, 30'h3FFFF800}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send the low nbits of bits, MSB first; models and checks the cascade tap.
    task automatic send_frame(input logic [63:0] bits, input int nbits);
        cs_i = 1'b1;
        wait_n(8);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdio_in_i = bits[i];
            wait_n(8);
            sclk_i = 1'b1;
            wait_n(8);
            if (cascade_o !== hist[63]) casc_err++;
            hist = {hist[62:0], bits[i]};
            sclk_i = 1'b0;
        end
        wait_n(4);
        cs_i = 1'b0;
        wait_n(10);
    endtask

    initial begin
        #3ms;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int sg1, sg2, sd, ss;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        chk({seg_g1_o, seg_g2_o, dim_word_o} == '0 && !ld_g1_o && !ld_g2_o &&
            !ld_dim_o && !ks_stop_o && !ks_read_o && !sdio_oe_o &&
            !sdio_out_o && !cascade_o, "R1 reset outputs",
            {seg_g1_o, dim_word_o}, 64'h0);

        // Vector table
        foreach (VEC[k]) begin
            logic [3:0]  m;
            logic [29:0] p;
            string       stag;
            m = VEC[k][33:30];
            p = VEC[k][29:0];
            sg1 = n_g1; sg2 = n_g2; sd = n_dim; ss = n_stop;
            casc_err = 0;
            send_frame({~p, p, m}, 64);
            if (m == 4'h1) exp_g1 = p;
            if (m == 4'h2) exp_g2 = p;
            if (m == 4'h3) exp_dim = p[10:0];
            chk(seg_g1_o == exp_g1, "R4 grid1 latch", 64'(seg_g1_o), 64'(exp_g1));
            chk(seg_g2_o == exp_g2, "R5 grid2 latch", 64'(seg_g2_o), 64'(exp_g2));
            chk(dim_word_o == exp_dim, "R6 dim latch", 64'(dim_word_o), 64'(exp_dim));
            stag = (m == 4'h5) ? "R7 stop strobe" :
                   (m == 4'h0 || m > 4'h5) ? "R8 ignored code" : "R12 strobe count";
            chk((n_g1 - sg1) == int'(m == 4'h1) && (n_g2 - sg2) == int'(m == 4'h2) &&
                (n_dim - sd) == int'(m == 4'h3) && (n_stop - ss) == int'(m == 4'h5),
                stag, 64'({n_g1 - sg1, n_g2 - sg2, n_dim - sd, n_stop - ss}),
                64'(m));
            chk(casc_err == 0, "R9 cascade delay", 64'(casc_err), 64'h0);
        end

        // R2: clock toggles with chip select low change nothing
        begin
            logic c0;
            c0 = cascade_o;
            for (int i = 0; i < 8; i++) begin
                sdio_in_i = ~cascade_o;
                wait_n(8); sclk_i = 1'b1; wait_n(8); sclk_i = 1'b0;
            end
            wait_n(8);
            chk(cascade_o == c0, "R2 cascade holds with cs low", 64'(cascade_o), 64'(c0));
            casc_err = 0;
            send_frame({30'h0, 30'h0ABCDEF0, 4'h2}, 64);
            exp_g2 = 30'h0ABCDEF0;
            chk(casc_err == 0 && seg_g2_o == exp_g2, "R2 no bits taken with cs low",
                64'(seg_g2_o), 64'(exp_g2));
        end

        // R3: 63 and 65 edges do not commit
        sg1 = n_g1;
        send_frame({30'h0, 30'h11111111, 4'h1}, 63);
        chk(seg_g1_o == exp_g1, "R3 short frame ignored", 64'(seg_g1_o), 64'(exp_g1));
        send_frame({30'h0, 30'h22222222, 4'h1}, 64);
        exp_g1 = 30'h22222222;
        chk(seg_g1_o == exp_g1, "R3 exact frame taken", 64'(seg_g1_o), 64'(exp_g1));
        send_frame({30'h0, 30'h33333333, 4'h1}, 64);
        send_frame({1'b1, 30'h0, 29'h0, 4'h1}, 64);
        exp_g1 = 30'h0;
        begin
            logic [63:0] longf;
            longf = {30'h3, 30'h05050505, 4'h1};
            send_frame(longf, 64);
            exp_g1 = 30'h05050505;
        end
        chk(seg_g1_o == exp_g1, "R3 reload after frames", 64'(seg_g1_o), 64'(exp_g1));
        send_frame({1'b0, 29'h0, 30'h06060606, 4'h1}, 64);
        exp_g1 = 30'h06060606;
        sg1 = n_g1;
        cs_i = 1'b1; wait_n(8);
        for (int i = 64; i >= 0; i--) begin
            sdio_in_i = (i == 0) ? 1'b1 : 1'b0;
            wait_n(8); sclk_i = 1'b1; wait_n(8); sclk_i = 1'b0;
            hist = {hist[62:0], sdio_in_i};
        end
        wait_n(4); cs_i = 1'b0; wait_n(10);
        chk(seg_g1_o == exp_g1 && n_g1 == sg1, "R3 long frame ignored",
            64'(seg_g1_o), 64'(exp_g1));

        // R10/R11: key read
        key_data_i = 30'h2D3C4B5A;
        casc_err = 0;
        send_frame({30'h0, 30'h0, 4'h4}, 64);
        key_data_i = 30'h01234567;
        chk(ks_read_o == 1'b1, "R10 read pending", 64'(ks_read_o), 64'h1);
        chk(sdio_oe_o == 1'b0, "R11 no drive while cs low", 64'(sdio_oe_o), 64'h0);
        begin
            int rd_err;
            logic [63:0] inj;
            rd_err = 0;
            inj = {30'h0, 30'h1BADCAFE, 4'h1};
            sg1 = n_g1;
            cs_i = 1'b1; wait_n(8);
            chk(sdio_oe_o == 1'b1, "R10 line turned to output", 64'(sdio_oe_o), 64'h1);
            for (int i = 0; i < 64; i++) begin
                sdio_in_i = inj[63 - i];
                wait_n(8);
                if (i < 30 && sdio_out_o !== key_data_i[29 - i] ^ 1'b0) begin
                    if (sdio_out_o !== logic'((30'h2D3C4B5A >> (29 - i)) & 30'h1)) rd_err++;
                end
                sclk_i = 1'b1; wait_n(8); sclk_i = 1'b0;
            end
            wait_n(4); cs_i = 1'b0; wait_n(10);
            chk(rd_err == 0, "R10 key bits MSB first", 64'(rd_err), 64'h0);
            chk(seg_g1_o == exp_g1 && n_g1 == sg1, "R10 input ignored in read window",
                64'(seg_g1_o), 64'(exp_g1));
            chk(ks_read_o == 1'b0 && sdio_oe_o == 1'b0, "R11 read ends, line released",
                64'({ks_read_o, sdio_oe_o}), 64'h0);
        end
        casc_err = 0;
        send_frame({30'h0, 30'h0000007F, 4'h3}, 64);
        exp_dim = 11'h07F;
        chk(dim_word_o == exp_dim && casc_err == 0, "R9 tap frozen during read",
            64'(casc_err), 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule